// File: doc/BRIEF.md
# Ping-Pong Colour Matrix

This block multiplies every three-channel pixel of a video stream by a 3x3 matrix and adds a per-channel offset, so the whole transform is affine. It holds two complete sets of twelve coefficients, bank A and bank B. Software fills the bank that is not live and then writes the mode word to request a change. The change is held back until the next frame-start strobe, so no frame is ever processed with a mixture of the two sets. A disable request is different: it takes effect at once.

The active mode is always visible on a status output. Software reads it and chooses its target bank from it: bank A when the status is anything other than A, and bank B otherwise. When the block is disabled, pixels pass through unchanged but take the same number of cycles as they do on the matrix path. Outputs are registered, and the pipeline is two cycles deep.

Top module: `ccm_pingpong`

## Requirements
- R1: After synchronous reset, `active_mode` is 0 (disabled), `out_valid` is 0, and every coefficient in both banks is 0.
- R2: The mode encoding is 0 for disabled, 1 for bank A and 2 for bank B. `active_mode` shows the mode that is applied to pixels and never shows 3.
- R3: A write to the mode word (address 12, bits [1:0]) of value 1 or 2 is held pending. `active_mode` takes that value in the cycle after the next `frame_start`, and stays unchanged until then. A strobe with nothing pending changes nothing.
- R4: Writing mode 0 sets `active_mode` to 0 in the next cycle, whether or not a strobe occurs, and discards any pending bank request.
- R5: Writing mode value 3 is ignored. It changes neither the active mode nor a pending request.
- R6: Coefficient words occupy addresses 0 to 5 for bank A and 6 to 11 for bank B. Each word carries two 16-bit coefficients, with the lower-numbered coefficient in bits [15:0]. The order within a bank is C11, C12, C13, C14, C21 and so on up to C34.
- R7: Each output channel i is computed as (Ci1*p0 + Ci2*p1 + Ci3*p2 + Ci4*2^13 + 2^12) >> 13, with arithmetic shift. The coefficients are signed 2.13 values and the offset Ci4 is a signed integer in pixel units. Channel 0 is carried in bits [PIX_W-1:0] of the pixel bus.
- R8: Results are saturated to the range 0 to 2^PIX_W-1.
- R9: An input pixel with `in_valid` appears on the output with `out_valid` exactly two cycles later. `out_valid` is never set without that input.
- R10: In mode 0 the pixel is passed through unchanged, with the same two-cycle latency.
- R11: A pixel presented in the same cycle as `frame_start` already uses the newly applied bank. Writing the idle bank has no effect on output pixels.
- R12: If a mode write of 1 or 2 occurs in the same cycle as `frame_start`, that written mode is applied at that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Word address: coefficients 0-11, mode 12 |
| wr_data | input | 2*COEF_W (32) | Write data |
| frame_start | input | 1 | One-cycle strobe marking a frame boundary |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 3*PIX_W (30) | Input pixel, channel 0 in the low bits |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 3*PIX_W (30) | Output pixel |
| active_mode | output | 2 | Currently applied mode |

## Verification
The bench targets the timing of bank changes.

- **Pending request.** A design that applied a request on the write itself, instead of waiting for the strobe, would show the new mode too early.
- **Disable during a pending request.** A design that kept the request after a disable would re-enable itself at the following strobe.
- **Mode write on the strobe cycle.** A design that ignored the write made in that cycle would hold the old mode for a whole frame.
- **Pixel on the strobe cycle.** A design that sampled the old mode for that pixel would process it with the previous frame's coefficients.
- **Arithmetic.** Negative coefficients, offsets and rounding push results past both rails. Saturation applied at the wrong width would wrap those results instead of clamping them.
- **Idle-bank writes.** Writes to the idle bank while the other bank is live must leave the output untouched.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_A   = 2'd1,
    MODE_B   = 2'd2
  } ccm_mode_e;
endpackage

// File: rtl/ccm_coef_store.sv
module ccm_coef_store #(
  parameter int COEF_W = 16,
  parameter int ADDR_W = 4,
  parameter int NCOEF  = 12
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   wr_en,
  input  logic [ADDR_W-1:0]                      wr_addr,
  input  logic [2*COEF_W-1:0]                    wr_data,
  output logic [1:0][NCOEF-1:0][COEF_W-1:0]      banks
);
  localparam int WPB = NCOEF / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      banks <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < 2; b++) begin
        for (int w = 0; w < WPB; w++) begin
          if (wr_addr == ADDR_W'(b * WPB + w)) begin
            banks[b][2*w]   <= wr_data[COEF_W-1:0];
            banks[b][2*w+1] <= wr_data[2*COEF_W-1:COEF_W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/ccm_mode_ctrl.sv
module ccm_mode_ctrl
  import ccm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mode_wr,
  input  logic [1:0] mode_val,
  input  logic      frame_start,
  output ccm_mode_e active,
  output ccm_mode_e active_nxt
);
  logic      pend_v;
  ccm_mode_e pend;
  logic      wr_off, wr_on;

  assign wr_off = mode_wr && (mode_val == 2'd0);
  assign wr_on  = mode_wr && (mode_val == 2'd1 || mode_val == 2'd2);

  always_comb begin
    active_nxt = active;
    if (wr_off)
      active_nxt = MODE_OFF;
    else if (frame_start) begin
      if (wr_on)
        active_nxt = ccm_mode_e'(mode_val);
      else if (pend_v)
        active_nxt = pend;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= MODE_OFF;
      pend_v <= 1'b0;
      pend   <= MODE_OFF;
    end else begin
      active <= active_nxt;
      if (wr_off || frame_start)
        pend_v <= 1'b0;
      else if (wr_on) begin
        pend_v <= 1'b1;
        pend   <= ccm_mode_e'(mode_val);
      end
    end
  end
endmodule

// File: rtl/ccm_row.sv
module ccm_row #(
  parameter int PIX_W  = 10,
  parameter int COEF_W = 16,
  parameter int FRAC   = 13
) (
  input  logic [2:0][PIX_W-1:0]  pix,
  input  logic [3:0][COEF_W-1:0] coef,
  output logic [PIX_W-1:0]       result
);
  localparam int SUM_W = COEF_W + PIX_W + 4;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (FRAC - 1);
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

  logic signed [SUM_W-1:0] c [4];
  logic signed [SUM_W-1:0] p [3];
  logic signed [SUM_W-1:0] acc, shr;

  always_comb begin
    for (int k = 0; k < 4; k++)
      c[k] = {{(SUM_W-COEF_W){coef[k][COEF_W-1]}}, coef[k]};
    for (int j = 0; j < 3; j++)
      p[j] = {{(SUM_W-PIX_W){1'b0}}, pix[j]};
    acc = c[0] * p[0] + c[1] * p[1] + c[2] * p[2] + (c[3] <<< FRAC) + HALF;
    shr = acc >>> FRAC;
    if (shr < 0)
      result = '0;
    else if (shr > MAXV)
      result = MAXV[PIX_W-1:0];
    else
      result = shr[PIX_W-1:0];
  end
endmodule

// File: rtl/ccm_pingpong.sv
module ccm_pingpong
  import ccm_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int COEF_W = 16,
  parameter int FRAC   = 13,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [2*COEF_W-1:0]  wr_data,
  input  logic                 frame_start,
  input  logic                 in_valid,
  input  logic [3*PIX_W-1:0]   in_pix,
  output logic                 out_valid,
  output logic [3*PIX_W-1:0]   out_pix,
  output logic [1:0]           active_mode
);
  localparam int NCOEF     = 12;
  localparam int MODE_ADDR = NCOEF;

  logic [1:0][NCOEF-1:0][COEF_W-1:0] banks;
  logic [NCOEF-1:0][COEF_W-1:0]      sel_coef;
  ccm_mode_e                         mode_q, mode_nxt, s1_mode;
  logic                              s1_v;
  logic [2:0][PIX_W-1:0]             s1_pix, mat_pix;
  logic                              mode_wr;

  assign mode_wr = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));

  ccm_coef_store #(.COEF_W(COEF_W), .ADDR_W(ADDR_W), .NCOEF(NCOEF)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .banks(banks)
  );

  ccm_mode_ctrl u_mode (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_val(wr_data[1:0]),
    .frame_start(frame_start), .active(mode_q), .active_nxt(mode_nxt)
  );

  // Stage 1: capture the pixel together with the mode it belongs to.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_pix  <= '0;
      s1_mode <= MODE_OFF;
    end else begin
      s1_v    <= in_valid;
      s1_pix  <= in_pix;
      s1_mode <= mode_nxt;
    end
  end

  assign sel_coef = (s1_mode == MODE_B) ? banks[1] : banks[0];

  for (genvar i = 0; i < 3; i++) begin : g_row
    ccm_row #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_row (
      .pix(s1_pix), .coef(sel_coef[i*4 +: 4]), .result(mat_pix[i])
    );
  end

  // Stage 2: registered output, bypass on the same latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s1_v;
      out_pix   <= (s1_mode == MODE_OFF) ? s1_pix : mat_pix;
    end
  end

  assign active_mode = mode_q;
endmodule

// File: rtl/ccm_checker.sv
module ccm_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              frame_start,
  input logic              in_valid,
  input logic              out_valid,
  input logic [1:0]        active_mode
);
  logic off_wr;
  assign off_wr = wr_en && (wr_addr == ADDR_W'(12)) && (wr_data[1:0] == 2'd0);

  assert_reset_state_R1: assert property (@(posedge clk)
    $fell(rst) |-> (active_mode == 2'd0 && !out_valid));

  assert_legal_mode_R2: assert property (@(posedge clk) disable iff (rst)
    active_mode != 2'd3);

  assert_hold_between_strobes_R3: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !off_wr) |=> $stable(active_mode));

  assert_disable_now_R4: assert property (@(posedge clk) disable iff (rst)
    off_wr |=> active_mode == 2'd0);

  assert_latency_fwd_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  assert_latency_back_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
endmodule

bind ccm_pingpong ccm_checker #(.ADDR_W(ADDR_W), .DATA_W(2*COEF_W)) u_ccm_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .frame_start(frame_start), .in_valid(in_valid), .out_valid(out_valid),
  .active_mode(active_mode)
);

// File: tb/tb_ccm_pingpong.sv
module tb_ccm_pingpong;
  localparam int PIX_W = 10;
  localparam int PW3   = 3 * PIX_W;
  localparam int MAXP  = (1 << PIX_W) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [3:0]      wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic            frame_start = 1'b0;
  logic            in_valid = 1'b0;
  logic [PW3-1:0]  in_pix = '0;
  logic            out_valid;
  logic [PW3-1:0]  out_pix;
  logic [1:0]      active_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  ccm_pingpong dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix), .active_mode(active_mode)
  );

  // ---------------- reference model ----------------
  int m_coef [2][12];
  int m_act, m_pv, m_pend;
  bit s1v, ev;
  int s1m;
  logic [PW3-1:0] s1p, ep;

  function automatic logic [PW3-1:0] pack(int c0, int c1, int c2);
    return {PIX_W'(c2), PIX_W'(c1), PIX_W'(c0)};
  endfunction

  function automatic logic [PW3-1:0] model_mat(int b, logic [PW3-1:0] p);
    logic [PW3-1:0] r;
    for (int i = 0; i < 3; i++) begin
      int acc = 4096 + m_coef[b][i*4+3] * 8192;
      for (int j = 0; j < 3; j++)
        acc += m_coef[b][i*4+j] * int'(p[j*PIX_W +: PIX_W]);
      acc = acc >>> 13;
      if (acc < 0) acc = 0;
      if (acc > MAXP) acc = MAXP;
      r[i*PIX_W +: PIX_W] = PIX_W'(acc);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_pv = 0; m_pend = 0; s1v = 0; ev = 0; s1m = 0; s1p = '0; ep = '0;
      for (int b = 0; b < 2; b++) for (int k = 0; k < 12; k++) m_coef[b][k] = 0;
    end else begin
      int nm, mv;
      bit mw;
      ev = s1v;
      if (s1v) ep = (s1m == 0) ? s1p : model_mat((s1m == 2) ? 1 : 0, s1p);
      mw = wr_en && wr_addr == 4'd12;
      mv = int'(wr_data[1:0]);
      nm = m_act;
      if (mw && mv == 0) nm = 0;
      else if (frame_start) begin
        if (mw && (mv == 1 || mv == 2)) nm = mv;
        else if (m_pv != 0) nm = m_pend;
      end
      if ((mw && mv == 0) || frame_start) m_pv = 0;
      else if (mw && (mv == 1 || mv == 2)) begin m_pv = 1; m_pend = mv; end
      m_act = nm;
      s1v = in_valid; s1p = in_pix; s1m = nm;
      if (wr_en && wr_addr < 4'd12) begin
        int b, w;
        b = (wr_addr >= 4'd6) ? 1 : 0;
        w = int'(wr_addr) - b * 6;
        m_coef[b][2*w]   = int'($signed(wr_data[15:0]));
        m_coef[b][2*w+1] = int'($signed(wr_data[31:16]));
      end
    end
  end

  task automatic check(bit ok, string req, logic [PW3-1:0] act, logic [PW3-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the clock edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(out_valid == ev, {phase, " valid"}, PW3'(out_valid), PW3'(ev));
      check(int'(active_mode) == m_act, {phase, " mode"}, PW3'(active_mode), PW3'(m_act));
      if (ev) check(out_pix == ep, {phase, " pixel"}, out_pix, ep);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, logic [31:0] d);
    wr_en = 1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic strobe();
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic px(logic [PW3-1:0] p);
    in_valid = 1; in_pix = p;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic px_expect(logic [PW3-1:0] p, logic [PW3-1:0] e, string req);
    px(p);
    @(negedge clk);
    check(out_valid && out_pix == e, req, out_pix, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    phase = "R1";
    check(active_mode == 2'd0 && !out_valid, "R1 reset", PW3'(active_mode), '0);

    // R10: bypass before any coefficients exist
    phase = "R10";
    px_expect(pack(100, 200, 300), pack(100, 200, 300), "R10 bypass");
    px_expect(pack(0, MAXP, 7), pack(0, MAXP, 7), "R10 bypass rails");

    // R6: bank A identity, bank B mixed matrix
    phase = "R6";
    wr(0, 32'h0000_2000); wr(1, 32'h0); wr(2, 32'h2000_0000);
    wr(3, 32'h0);         wr(4, 32'h0); wr(5, 32'h0000_2000);
    wr(6, 32'h0000_E000); wr(7, 32'h03E8_0000); wr(8, 32'h4000_0000);
    wr(9, 32'h0);         wr(10, 32'h1000_1000); wr(11, 32'hFFFB_0000);

    // R3: request bank A, held until strobe
    phase = "R3";
    wr(12, 32'd1);
    repeat (3) @(negedge clk);
    check(active_mode == 2'd0, "R3 pending held", PW3'(active_mode), '0);
    strobe();
    check(active_mode == 2'd1, "R3 applied on strobe", PW3'(active_mode), PW3'(1));
    strobe();
    check(active_mode == 2'd1, "R3 empty strobe", PW3'(active_mode), PW3'(1));
    phase = "R7";
    px_expect(pack(100, 200, 300), pack(100, 200, 300), "R7 identity");

    // R12: mode write and strobe together
    phase = "R12";
    wr_en = 1; wr_addr = 4'd12; wr_data = 32'd2; frame_start = 1;
    @(negedge clk);
    wr_en = 0; frame_start = 0;
    check(active_mode == 2'd2, "R12 same-cycle apply", PW3'(active_mode), PW3'(2));

    // R7 / R8: bank B arithmetic with saturation both ways
    phase = "R8";
    px_expect(pack(200, 600, 7), pack(800, MAXP, 395), "R8 high clamp");
    px_expect(pack(5, 3, 0), pack(995, 6, 0), "R8 low clamp");
    phase = "R7";
    px_expect(pack(1, 2, 3), pack(999, 4, 0), "R7 rounding");

    // R11: idle bank write has no effect on output
    phase = "R11";
    wr(0, 32'h0000_7FFF);
    px_expect(pack(200, 600, 7), pack(800, MAXP, 395), "R11 idle write");
    wr(0, 32'h0000_2000);

    // R5: illegal value 3 is ignored, pending stays clear
    phase = "R5";
    wr(12, 32'd3);
    @(negedge clk);
    check(active_mode == 2'd2, "R5 ignore now", PW3'(active_mode), PW3'(2));
    strobe();
    check(active_mode == 2'd2, "R5 ignore at strobe", PW3'(active_mode), PW3'(2));

    // R11: pixel on the strobe cycle uses the new bank
    phase = "R11";
    wr(12, 32'd1);
    frame_start = 1; in_valid = 1; in_pix = pack(200, 600, 7);
    @(negedge clk);
    frame_start = 0; in_valid = 0;
    @(negedge clk);
    check(out_valid && out_pix == pack(200, 600, 7), "R11 strobe pixel",
          out_pix, pack(200, 600, 7));

    // R4: disable overrides a pending request immediately
    phase = "R4";
    wr(12, 32'd2);
    wr(12, 32'd0);
    check(active_mode == 2'd0, "R4 disable now", PW3'(active_mode), '0);
    strobe();
    check(active_mode == 2'd0, "R4 pending dropped", PW3'(active_mode), '0);
    phase = "R10";
    px_expect(pack(11, 22, 33), pack(11, 22, 33), "R10 bypass after disable");

    // R9: back-to-back stream
    phase = "R9";
    wr(12, 32'd2); strobe();
    for (int i = 0; i < 20; i++) begin
      in_valid = (i % 3 != 1); in_pix = pack(i * 37, 1000 - i * 40, i * 11);
      @(negedge clk);
    end
    in_valid = 0;
    repeat (4) @(negedge clk);

    // R2: status shows bank B and never 3
    phase = "R2";
    check(active_mode == 2'd2, "R2 status", PW3'(active_mode), PW3'(2));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule